// File: doc/BRIEF.md
# Control-Flow Signature Checker

This block guards a processor against program-counter corruption. It builds a running signature over the path that a function actually takes. When a function is entered, the sequencer loads a per-function seed. Every retired instruction then mixes its identifier into the signature, so the value at function exit depends on which branches were taken.

When the function ends, the signature is compared in a single cycle against a small on-chip table of permitted exit values for that function. A match closes the function cleanly. A miss raises a sticky fault that halts execution until a global reset. The table is written only while a configuration enable is high. Each function has a fixed number of slots, and each slot carries its own valid flag.

Top module: `cflow_sig_check`

## Requirements
- R1: After reset, `fault_o`, `active_o`, `end_ok_o` and `sig_o` are all 0, and every table slot is invalid.
- R2: A `start_i` pulse loads `seed_i` into `sig_o` and sets `active_o` to 1 one cycle later.
- R3: A `retire_i` pulse replaces the signature with the old value rotated left by one bit, XORed with `instr_id_i`; the new value is visible one cycle later.
- R4: An `end_i` pulse on an active function whose signature equals any valid slot of table row `end_func_i` gives a one-cycle `end_ok_o` pulse and clears `active_o`, with `fault_o` staying 0.
- R5: An `end_i` pulse whose signature matches no valid slot of its row sets `fault_o`; a slot holding an equal value with its valid flag 0 does not match.
- R6: An `end_i` pulse while `active_o` is 0 sets `fault_o`.
- R7: `fault_o` stays 1 until reset. While it is 1, `start_i`, `retire_i` and `end_i` leave `sig_o` and `active_o` unchanged and produce no `end_ok_o`.
- R8: A table write (`tbl_we_i`) while `cfg_en_i` is 0 leaves the table unchanged.
- R9: When strobes coincide in one cycle, only one acts, in the order start, then end, then retire. The end check uses the signature held before that cycle.
- R10: The lookup uses only row `end_func_i`; an exit value stored only in another function's row does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_en_i | input | 1 | Configuration phase; table writes allowed |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_func_i | input | 4 | Table row (function index) to write |
| tbl_slot_i | input | 3 | Slot within the row |
| tbl_val_i | input | 16 | Allowed exit signature |
| tbl_valid_i | input | 1 | Valid flag written with the slot |
| start_i | input | 1 | Function entry strobe |
| seed_i | input | 16 | Seed loaded at entry |
| retire_i | input | 1 | Instruction retire strobe |
| instr_id_i | input | 16 | Identifier of the retired instruction |
| end_i | input | 1 | Function exit strobe |
| end_func_i | input | 4 | Index of the exiting function |
| sig_o | output | 16 | Running signature |
| active_o | output | 1 | A function is open |
| end_ok_o | output | 1 | One-cycle pulse on a passing exit check |
| fault_o | output | 1 | Sticky control-flow fault / halt |

## Verification
The hardest case to reach is a wrong exit: a valid signature must land exactly on a slot value whose valid flag is clear, or in another function's row, or arrive through a table write that was blocked. Once the fault is raised it latches, so every such case needs its own reset and a full table reload. The bench computes each exit value from deterministic per-function paths and seeds. It writes every path value for slots 0 to 6 as valid and the slot 7 value as invalid. It then runs the slot 7 path, a cross-row exit and a write blocked by `cfg_en_i` low, each after a fresh reset. Random passes pick a function and a path at random, and check the signature after every retire.

// File: rtl/cflow_sig_pkg.sv
package cflow_sig_pkg;
  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_START  = 2'd1,
    EV_END    = 2'd2,
    EV_RETIRE = 2'd3
  } cf_ev_e;
endpackage

// File: rtl/cflow_sig_arb.sv
module cflow_sig_arb
  import cflow_sig_pkg::*;
(
  input  logic   halted_i,
  input  logic   start_i,
  input  logic   end_i,
  input  logic   retire_i,
  output cf_ev_e ev_o
);
  always_comb begin
    ev_o = EV_NONE;
    if (!halted_i) begin
      if (start_i)       ev_o = EV_START;
      else if (end_i)    ev_o = EV_END;
      else if (retire_i) ev_o = EV_RETIRE;
    end
  end
endmodule

// File: rtl/cflow_sig_accum.sv
module cflow_sig_accum
  import cflow_sig_pkg::*;
#(
  parameter int SIG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cf_ev_e           ev_i,
  input  logic [SIG_W-1:0] seed_i,
  input  logic [SIG_W-1:0] id_i,
  output logic [SIG_W-1:0] sig_o
);
  logic [SIG_W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_q <= '0;
    end else begin
      case (ev_i)
        EV_START:  sig_q <= seed_i;
        EV_RETIRE: sig_q <= {sig_q[SIG_W-2:0], sig_q[SIG_W-1]} ^ id_i;
        default:   ;
      endcase
    end
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/cflow_sig_table.sv
module cflow_sig_table #(
  parameter int SIG_W  = 16,
  parameter int FUNC_N = 16,
  parameter int SLOT_N = 8,
  localparam int FUNC_AW = (FUNC_N > 1) ? $clog2(FUNC_N) : 1,
  localparam int SLOT_AW = (SLOT_N > 1) ? $clog2(SLOT_N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [FUNC_AW-1:0] wr_func_i,
  input  logic [SLOT_AW-1:0] wr_slot_i,
  input  logic [SIG_W-1:0]   wr_val_i,
  input  logic               wr_valid_i,
  input  logic [FUNC_AW-1:0] rd_func_i,
  input  logic [SIG_W-1:0]   sig_i,
  output logic               hit_o
);
  logic [SIG_W-1:0]  val_q [FUNC_N][SLOT_N];
  logic [SLOT_N-1:0] vld_q [FUNC_N];
  logic [SLOT_N-1:0] hit_vec;
  logic              wr_in_range;
  logic              rd_in_range;

  assign wr_in_range = (int'(wr_func_i) < FUNC_N) && (int'(wr_slot_i) < SLOT_N);
  assign rd_in_range = int'(rd_func_i) < FUNC_N;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int f = 0; f < FUNC_N; f++) vld_q[f] <= '0;
    end else if (we_i && wr_in_range) begin
      vld_q[wr_func_i][wr_slot_i] <= wr_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i && wr_in_range) val_q[wr_func_i][wr_slot_i] <= wr_val_i;
  end

  // all slots of the selected row compared in parallel
  for (genvar s = 0; s < SLOT_N; s++) begin : g_slot
    assign hit_vec[s] = rd_in_range && vld_q[rd_func_i][s] &&
                        (val_q[rd_func_i][s] == sig_i);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/cflow_sig_check.sv
module cflow_sig_check
  import cflow_sig_pkg::*;
#(
  parameter int SIG_W  = 16,
  parameter int FUNC_N = 16,
  parameter int SLOT_N = 8,
  localparam int FUNC_AW = (FUNC_N > 1) ? $clog2(FUNC_N) : 1,
  localparam int SLOT_AW = (SLOT_N > 1) ? $clog2(SLOT_N) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_en_i,
  input  logic               tbl_we_i,
  input  logic [FUNC_AW-1:0] tbl_func_i,
  input  logic [SLOT_AW-1:0] tbl_slot_i,
  input  logic [SIG_W-1:0]   tbl_val_i,
  input  logic               tbl_valid_i,
  input  logic               start_i,
  input  logic [SIG_W-1:0]   seed_i,
  input  logic               retire_i,
  input  logic [SIG_W-1:0]   instr_id_i,
  input  logic               end_i,
  input  logic [FUNC_AW-1:0] end_func_i,
  output logic [SIG_W-1:0]   sig_o,
  output logic               active_o,
  output logic               end_ok_o,
  output logic               fault_o
);
  cf_ev_e ev;
  logic   hit;
  logic   active_q, fault_q, end_ok_q;

  cflow_sig_arb u_arb (
    .halted_i (fault_q),
    .start_i  (start_i),
    .end_i    (end_i),
    .retire_i (retire_i),
    .ev_o     (ev)
  );

  cflow_sig_accum #(.SIG_W(SIG_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .seed_i (seed_i),
    .id_i   (instr_id_i),
    .sig_o  (sig_o)
  );

  cflow_sig_table #(.SIG_W(SIG_W), .FUNC_N(FUNC_N), .SLOT_N(SLOT_N)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (tbl_we_i & cfg_en_i),
    .wr_func_i  (tbl_func_i),
    .wr_slot_i  (tbl_slot_i),
    .wr_val_i   (tbl_val_i),
    .wr_valid_i (tbl_valid_i),
    .rd_func_i  (end_func_i),
    .sig_i      (sig_o),
    .hit_o      (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      fault_q  <= 1'b0;
      end_ok_q <= 1'b0;
    end else begin
      end_ok_q <= 1'b0;
      case (ev)
        EV_START: active_q <= 1'b1;
        EV_END: begin
          active_q <= 1'b0;
          if (active_q && hit) end_ok_q <= 1'b1;
          else                 fault_q  <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign active_o = active_q;
  assign end_ok_o = end_ok_q;
  assign fault_o  = fault_q;
endmodule

// File: rtl/cflow_sig_check_sva.sv
module cflow_sig_check_sva #(
  parameter int SIG_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [SIG_W-1:0] seed_i,
  input logic             retire_i,
  input logic [SIG_W-1:0] instr_id_i,
  input logic             end_i,
  input logic [SIG_W-1:0] sig_o,
  input logic             active_o,
  input logic             end_ok_o,
  input logic             fault_o
);
  // R2
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !fault_o |=> (sig_o == $past(seed_i)) && active_o);

  // R3
  retire_fold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && !start_i && !end_i && !fault_o |=>
      sig_o == ({$past(sig_o[SIG_W-2:0]), $past(sig_o[SIG_W-1])} ^ $past(instr_id_i)));

  // R6
  orphan_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i && !start_i && !active_o |=> fault_o);

  // R7
  fault_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> fault_o && $stable(sig_o) && $stable(active_o) && !end_ok_o);

  // R4
  end_ok_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_ok_o |-> !fault_o && !active_o);

  // R4
  end_ok_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(end_ok_o) |-> $past(end_i) && $past(active_o));
endmodule

bind cflow_sig_check cflow_sig_check_sva #(.SIG_W(SIG_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .seed_i     (seed_i),
  .retire_i   (retire_i),
  .instr_id_i (instr_id_i),
  .end_i      (end_i),
  .sig_o      (sig_o),
  .active_o   (active_o),
  .end_ok_o   (end_ok_o),
  .fault_o    (fault_o)
);

// File: tb/cflow_sig_check_bench.sv
module cflow_sig_check_bench;
  localparam int SIG_W  = 16;
  localparam int FUNC_N = 16;
  localparam int SLOT_N = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_en_i = 1'b0;
  logic             tbl_we_i = 1'b0;
  logic [3:0]       tbl_func_i = '0;
  logic [2:0]       tbl_slot_i = '0;
  logic [SIG_W-1:0] tbl_val_i = '0;
  logic             tbl_valid_i = 1'b0;
  logic             start_i = 1'b0;
  logic [SIG_W-1:0] seed_i = '0;
  logic             retire_i = 1'b0;
  logic [SIG_W-1:0] instr_id_i = '0;
  logic             end_i = 1'b0;
  logic [3:0]       end_func_i = '0;
  logic [SIG_W-1:0] sig_o;
  logic             active_o, end_ok_o, fault_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [SIG_W-1:0] exp_sig;

  cflow_sig_check #(.SIG_W(SIG_W), .FUNC_N(FUNC_N), .SLOT_N(SLOT_N)) u_cflow_sig_check (
    .clk_i, .rst_ni, .cfg_en_i, .tbl_we_i, .tbl_func_i, .tbl_slot_i, .tbl_val_i,
    .tbl_valid_i, .start_i, .seed_i, .retire_i, .instr_id_i, .end_i, .end_func_i,
    .sig_o, .active_o, .end_ok_o, .fault_o
  );

  always #5ns clk_i = ~clk_i;

  function automatic logic [SIG_W-1:0] rotl(input logic [SIG_W-1:0] v);
    return {v[SIG_W-2:0], v[SIG_W-1]};
  endfunction

  function automatic logic [SIG_W-1:0] seed_of(input int f);
    return SIG_W'(f * 40503) ^ 16'h5A5A;
  endfunction

  function automatic logic [SIG_W-1:0] id_of(input int f, input int s, input int i);
    return SIG_W'((f * 131 + s * 37 + i * 17 + 5) * 40503) ^ SIG_W'(i << 7);
  endfunction

  function automatic logic [SIG_W-1:0] path_sig(input int f, input int s);
    logic [SIG_W-1:0] v = seed_of(f);
    for (int i = 0; i < s + 2; i++) v = rotl(v) ^ id_of(f, s, i);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic tbl_write(input int f, input int s, input logic [SIG_W-1:0] v, input logic vld);
    tbl_we_i = 1'b1; tbl_func_i = 4'(f); tbl_slot_i = 3'(s);
    tbl_val_i = v; tbl_valid_i = vld;
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  // slots 0..6 valid with their path value, slot 7 written with its path value but invalid
  task automatic configure();
    cfg_en_i = 1'b1;
    for (int f = 0; f < FUNC_N; f++)
      for (int s = 0; s < SLOT_N; s++) tbl_write(f, s, path_sig(f, s), s < 7);
    cfg_en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic do_start(input logic [SIG_W-1:0] sd);
    start_i = 1'b1; seed_i = sd;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic do_retire(input logic [SIG_W-1:0] id);
    retire_i = 1'b1; instr_id_i = id;
    @(negedge clk_i);
    retire_i = 1'b0;
  endtask

  task automatic do_end(input int f);
    end_i = 1'b1; end_func_i = 4'(f);
    @(negedge clk_i);
    end_i = 1'b0;
  endtask

  task automatic run_path(input int f, input int s, input int ef);
    do_start(seed_of(f));
    check("R2 sig", 32'(sig_o), 32'(seed_of(f)));
    check("R2 active", 32'(active_o), 32'd1);
    exp_sig = seed_of(f);
    for (int i = 0; i < s + 2; i++) begin
      do_retire(id_of(f, s, i));
      exp_sig = rotl(exp_sig) ^ id_of(f, s, i);
      check("R3 fold", 32'(sig_o), 32'(exp_sig));
    end
    do_end(ef);
  endtask

  initial begin
    #1ms;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    reset_dut();
    // R1
    check("R1 fault", 32'(fault_o), 0);
    check("R1 active", 32'(active_o), 0);
    check("R1 sig", 32'(sig_o), 0);
    check("R1 end_ok", 32'(end_ok_o), 0);

    // R6 end with nothing open
    do_end(0);
    check("R6 fault", 32'(fault_o), 1);
    // R7 strobes ignored after fault
    do_retire(16'hBEEF);
    check("R7 sig stable", 32'(sig_o), 0);
    do_start(16'h1234);
    check("R7 start ignored", 32'(active_o), 0);
    check("R7 sig after start", 32'(sig_o), 0);
    repeat (3) @(negedge clk_i);
    check("R7 still fault", 32'(fault_o), 1);

    // R4 random passing paths
    reset_dut();
    configure();
    for (int k = 0; k < 300; k++) begin
      int f = int'($urandom_range(FUNC_N - 1, 0));
      int s = int'($urandom_range(6, 0));
      run_path(f, s, f);
      check("R4 end_ok", 32'(end_ok_o), 1);
      check("R4 no fault", 32'(fault_o), 0);
      check("R4 active cleared", 32'(active_o), 0);
      @(negedge clk_i);
      check("R4 pulse one cycle", 32'(end_ok_o), 0);
    end

    // R9 start beats retire; end beats retire and uses prior signature
    start_i = 1'b1; seed_i = seed_of(5); retire_i = 1'b1; instr_id_i = 16'hFFFF;
    @(negedge clk_i);
    start_i = 1'b0; retire_i = 1'b0;
    check("R9 start wins", 32'(sig_o), 32'(seed_of(5)));
    do_retire(id_of(5, 0, 0));
    do_retire(id_of(5, 0, 1));
    end_i = 1'b1; end_func_i = 4'd5; retire_i = 1'b1; instr_id_i = 16'h0F0F;
    @(negedge clk_i);
    end_i = 1'b0; retire_i = 1'b0;
    check("R9 end wins", 32'(end_ok_o), 1);
    check("R9 sig untouched", 32'(sig_o), 32'(path_sig(5, 0)));
    check("R9 no fault", 32'(fault_o), 0);

    // R5 value present but slot invalid
    run_path(2, 7, 2);
    check("R5 invalid slot", 32'(fault_o), 1);
    check("R5 no end_ok", 32'(end_ok_o), 0);

    // R8 write while cfg_en low ignored
    reset_dut();
    configure();
    tbl_write(1, 7, path_sig(1, 7), 1'b1);
    @(negedge clk_i);
    run_path(1, 7, 1);
    check("R8 write ignored", 32'(fault_o), 1);

    // R10 exit value of another row
    reset_dut();
    configure();
    begin
      logic in_row4 = 1'b0;
      for (int s = 0; s < 7; s++) if (path_sig(4, s) == path_sig(3, 0)) in_row4 = 1'b1;
      run_path(3, 0, 4);
      check("R10 other row", 32'(fault_o), 32'(!in_row4));
    end
    // R7 sticky, end_ok never after fault
    do_start(seed_of(3));
    do_end(3);
    check("R7 no end_ok", 32'(end_ok_o), 0);
    check("R7 fault held", 32'(fault_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule